// File: doc/BRIEF.md
# Multi-Channel Periodic Interrupt Timer

This block is a bank of independent down-counting timers that sits on a simple register bus. Each channel counts down from a programmed reload value. When it passes through zero it raises a timeout flag, takes the reload value again and keeps running, so every channel is periodic by nature. Software gets one-shot behaviour by stopping the channel from its interrupt handler.

A single module-level control register can freeze every channel at once. Any channel above channel 0 can be switched into a cascade mode. In that mode it decrements once per expiry of the channel just below it, so a pair of channels acts as one wide counter. Changing a channel's reload value never disturbs the period already in progress. Turning the enable bit off and back on loads the new value at once.

The bus is a plain single-cycle port. Writes commit on the clock edge where `bus_sel` and `bus_wr` are both high. Reads are combinational while `bus_sel` is high and `bus_wr` is low. Each channel drives its own level-sensitive interrupt line.

Top module: `multi_chan_timer`

## Requirements
- R1: After reset every register reads zero, except the module control register, which reads 0x2 (freeze bit set). All interrupt lines are low.
- R2: While bit 1 of the module control register is 1, no channel's count changes except by the enable-start load of R3. Writing that bit to 0 lets enabled channels run from the following clock edge.
- R3: Writing a channel control word whose bit 0 (enable) goes from 0 to 1 makes the count equal the reload value after that write's clock edge. While enable is 0 the count holds and the timeout flag is never set.
- R4: A running channel decrements by one per clock. At the edge where the count is 0 it instead reloads from the reload register and sets its timeout flag. A reload value of N gives one expiry every N+1 cycles.
- R5: Writing the reload register while the channel runs leaves the current count untouched. The new value is used at the next reload.
- R6: Bit 0 of a channel flag register is cleared by writing 1 and unchanged by writing 0. An expiry in the same cycle as a clear leaves the flag set.
- R7: A channel's interrupt line is high exactly when its timeout flag is set and bit 1 (interrupt enable) of its control word is 1.
- R8: A channel n >= 1 whose control bit 2 (cascade) is set decrements, reloads and expires only on clock edges where channel n-1 expires, not on every clock.
- R9: The cascade bit has no effect on channel 0, which counts every clock when running.
- R10: The current-count register is read-only; writes to it change nothing.
- R11: The module control register is at 0x000. Channel n occupies 0x100 + 0x10*n, holding the reload value at +0x0, the current count at +0x4, the control word at +0x8 and the flag at +0xC. Control reads back bits 2:0, and any unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (9) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational |
| irq | output | NUM_CH (4) | Per-channel interrupt lines |

## Verification
A register write takes effect on the clock edge that samples it. The reload, count and flag values it causes can be read back combinationally in the half cycle after that edge. Every running channel also moves once per later edge, including the edge consumed by each further bus write. The bench drives and reads at the falling edge and counts every rising edge between stimulus and read. Expected counts therefore come straight from the load value minus elapsed edges, wrapping at N+1. For cascaded channels the bench counts expiries of the lower channel instead of clocks.

// File: rtl/mct_pkg.sv
package mct_pkg;

  typedef enum logic [1:0] {
    REG_RELOAD = 2'd0,
    REG_COUNT  = 2'd1,
    REG_CTRL   = 2'd2,
    REG_FLAG   = 2'd3
  } chan_reg_e;

  typedef struct packed {
    logic cascade;
    logic irq_en;
    logic run_en;
  } chan_ctl_t;

  localparam int CTL_W = 3;

endpackage

// File: rtl/mct_channel.sv
module mct_channel
  import mct_pkg::*;
#(
  parameter int IDX    = 0,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_run_i,
  input  logic              wr_reload_i,
  input  logic              wr_ctrl_i,
  input  logic              wr_flag_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              lower_exp_i,
  output logic [DATA_W-1:0] reload_o,
  output logic [DATA_W-1:0] count_o,
  output chan_ctl_t         ctl_o,
  output logic              flag_o,
  output logic              expire_o,
  output logic              irq_o
);

  logic [DATA_W-1:0] reload_q, count_q;
  chan_ctl_t         ctl_q;
  logic              flag_q;
  logic              start, running, tick, cascaded, at_zero;
  logic              unused_wbits;

  assign unused_wbits = ^wdata_i[DATA_W-1:CTL_W];

  generate
    if (IDX > 0) begin : g_casc
      assign cascaded = ctl_q.cascade;
    end else begin : g_nocasc
      logic unused_casc;
      assign unused_casc = lower_exp_i;
      assign cascaded    = 1'b0;
    end
  endgenerate

  assign start    = wr_ctrl_i && wdata_i[0] && !ctl_q.run_en;
  assign running  = mod_run_i && ctl_q.run_en;
  assign tick     = cascaded ? lower_exp_i : 1'b1;
  assign at_zero  = (count_q == '0);
  assign expire_o = running && tick && at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      count_q  <= '0;
      ctl_q    <= '0;
      flag_q   <= 1'b0;
    end else begin
      if (wr_reload_i) reload_q <= wdata_i;
      if (wr_ctrl_i)   ctl_q    <= chan_ctl_t'(wdata_i[CTL_W-1:0]);
      if (start)
        count_q <= reload_q;
      else if (running && tick)
        count_q <= at_zero ? reload_q : count_q - 1'b1;
      if (expire_o)
        flag_q <= 1'b1;
      else if (wr_flag_i && wdata_i[0])
        flag_q <= 1'b0;
    end
  end

  assign reload_o = reload_q;
  assign count_o  = count_q;
  assign ctl_o    = ctl_q;
  assign flag_o   = flag_q;
  assign irq_o    = flag_q && ctl_q.irq_en;

  // Assertions
  assert_start_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> count_q == $past(reload_q));

  assert_frozen_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_run_i && !start) |=> $stable(count_q));

  assert_no_flag_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.run_en && !flag_q) |=> !flag_q);

  assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && !at_zero && !start) |=> count_q == $past(count_q) - 1'b1);

  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && at_zero) |=> count_q == $past(reload_q));

  assert_flag_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> flag_q);

  assert_cascade_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cascaded && !lower_exp_i && !start) |=> $stable(count_q));

endmodule

// File: rtl/mct_readmux.sv
module mct_readmux
  import mct_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 9
) (
  input  logic                           rd_en_i,
  input  logic                           mcr_hit_i,
  input  logic                           ch_hit_i,
  input  logic [$clog2(NUM_CH+1)-1:0]    ch_idx_i,
  input  chan_reg_e                      reg_sel_i,
  input  logic                           freeze_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  reload_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  count_i,
  input  chan_ctl_t [NUM_CH-1:0]         ctl_i,
  input  logic [NUM_CH-1:0]              flag_i,
  output logic [DATA_W-1:0]              rdata_o
);

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (mcr_hit_i) begin
        rdata_o[1] = freeze_i;
      end else if (ch_hit_i) begin
        unique case (reg_sel_i)
          REG_RELOAD: rdata_o = reload_i[ch_idx_i];
          REG_COUNT:  rdata_o = count_i[ch_idx_i];
          REG_CTRL:   rdata_o[CTL_W-1:0] = ctl_i[ch_idx_i];
          REG_FLAG:   rdata_o[0] = flag_i[ch_idx_i];
          default:    rdata_o = '0;
        endcase
      end
    end
  end

  always_comb begin
    if (rd_en_i && ch_hit_i)
      assert_idx_in_range_R11: assert (ch_idx_i < NUM_CH);
  end

endmodule

// File: rtl/multi_chan_timer.sv
module multi_chan_timer
  import mct_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq
);

  localparam int CH_LSB = 4;
  localparam int CH_W   = ADDR_W - 1 - CH_LSB;
  localparam int IDX_W  = $clog2(NUM_CH + 1);

  logic              freeze_q;
  logic              mcr_hit, ch_hit, wr_en, rd_en;
  logic [CH_W-1:0]   ch_field;
  logic [IDX_W-1:0]  ch_idx;
  chan_reg_e         reg_sel;

  logic [NUM_CH-1:0][DATA_W-1:0] reload_a, count_a;
  chan_ctl_t [NUM_CH-1:0]        ctl_a;
  logic [NUM_CH-1:0]             flag_a, expire_a;

  assign wr_en    = bus_sel && bus_wr;
  assign rd_en    = bus_sel && !bus_wr;
  assign ch_field = bus_addr[ADDR_W-2:CH_LSB];
  assign ch_idx   = IDX_W'(ch_field);
  assign reg_sel  = chan_reg_e'(bus_addr[3:2]);
  assign mcr_hit  = (bus_addr == '0);
  assign ch_hit   = bus_addr[ADDR_W-1] && (bus_addr[1:0] == 2'b00) &&
                    (32'(ch_field) < NUM_CH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                freeze_q <= 1'b1;
    else if (wr_en && mcr_hit) freeze_q <= bus_wdata[1];
  end

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic sel_me, lower_exp;
      assign sel_me = wr_en && ch_hit && (ch_idx == IDX_W'(i));
      if (i == 0) begin : g_bottom
        assign lower_exp = 1'b0;
      end else begin : g_upper
        assign lower_exp = expire_a[i-1];
      end
      mct_channel #(.IDX(i), .DATA_W(DATA_W)) u_ch (
        .clk         (clk),
        .rst_n       (rst_n),
        .mod_run_i   (!freeze_q),
        .wr_reload_i (sel_me && reg_sel == REG_RELOAD),
        .wr_ctrl_i   (sel_me && reg_sel == REG_CTRL),
        .wr_flag_i   (sel_me && reg_sel == REG_FLAG),
        .wdata_i     (bus_wdata),
        .lower_exp_i (lower_exp),
        .reload_o    (reload_a[i]),
        .count_o     (count_a[i]),
        .ctl_o       (ctl_a[i]),
        .flag_o      (flag_a[i]),
        .expire_o    (expire_a[i]),
        .irq_o       (irq[i])
      );
    end
  endgenerate

  mct_readmux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .rd_en_i   (rd_en),
    .mcr_hit_i (mcr_hit),
    .ch_hit_i  (ch_hit),
    .ch_idx_i  (ch_idx),
    .reg_sel_i (reg_sel),
    .freeze_i  (freeze_q),
    .reload_i  (reload_a),
    .count_i   (count_a),
    .ctl_i     (ctl_a),
    .flag_i    (flag_a),
    .rdata_o   (bus_rdata)
  );

  assert_no_expire_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_q |-> (expire_a == '0));

  assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~flag_a) == '0);

endmodule

// File: tb/multi_chan_timer_test.sv
`timescale 1ns/1ps
module multi_chan_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  multi_chan_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [8:0] ra(input int ch, input int off);
    return 9'(32'h100 + 32'h10 * ch + off);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #0.05;
    d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic rdchk(input string req, input logic [8:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rdchk("R1 mcr", 9'h000, 32'h2);
    for (int c = 0; c < 4; c++)
      for (int o = 0; o < 16; o += 4)
        rdchk("R1 chan reg", ra(c, o), 32'h0);
    check("R1 irq", {28'h0, irq}, 32'h0);
  endtask

  task automatic t_count_flag;
    wr(ra(0, 0), 5);
    wr(ra(0, 8), 1);
    rdchk("R3 start load", ra(0, 4), 5);
    wait_cyc(3);
    rdchk("R2 frozen", ra(0, 4), 5);
    wr(9'h000, 0);
    rdchk("R11 mcr readback", 9'h000, 0);
    rdchk("R2 edge of unfreeze", ra(0, 4), 5);
    wait_cyc(2);
    rdchk("R4 decrement", ra(0, 4), 3);
    wait_cyc(3);
    rdchk("R4 at zero", ra(0, 4), 0);
    rdchk("R4 flag not yet", ra(0, 12), 0);
    wait_cyc(1);
    rdchk("R4 reload", ra(0, 4), 5);
    rdchk("R4 flag set", ra(0, 12), 1);
    check("R7 irq masked", {31'h0, irq[0]}, 0);
    wr(ra(0, 8), 3);
    rdchk("R11 ctrl readback", ra(0, 8), 3);
    check("R7 irq on", {31'h0, irq[0]}, 1);
    wr(ra(0, 12), 0);
    rdchk("R6 write0 keeps", ra(0, 12), 1);
    wr(ra(0, 12), 1);
    rdchk("R6 write1 clears", ra(0, 12), 0);
    check("R7 irq off", {31'h0, irq[0]}, 0);
    rdchk("R4 still counting", ra(0, 4), 2);
  endtask

  task automatic t_reload_write;
    wr(ra(0, 0), 10);
    rdchk("R5 count undisturbed", ra(0, 4), 1);
    wait_cyc(2);
    rdchk("R5 new value at reload", ra(0, 4), 10);
    rdchk("R5 flag", ra(0, 12), 1);
  endtask

  task automatic t_disable;
    wr(ra(0, 8), 0);
    rdchk("R3 last edge runs", ra(0, 4), 9);
    wr(ra(0, 12), 1);
    wait_cyc(15);
    rdchk("R3 hold", ra(0, 4), 9);
    rdchk("R3 no flag", ra(0, 12), 0);
    wr(ra(0, 4), 123);
    rdchk("R10 count read-only", ra(0, 4), 9);
    wr(ra(0, 8), 1);
    rdchk("R3 restart reload", ra(0, 4), 10);
  endtask

  task automatic t_cascade;
    wr(ra(2, 0), 2);
    wr(ra(3, 0), 1);
    wr(ra(3, 8), 5);
    rdchk("R11 ctrl bits", ra(3, 8), 5);
    wr(ra(2, 8), 1);
    rdchk("R8 upper waits", ra(3, 4), 1);
    wait_cyc(2);
    rdchk("R8 no tick yet", ra(3, 4), 1);
    rdchk("R8 lower at zero", ra(2, 4), 0);
    wait_cyc(1);
    rdchk("R8 one tick", ra(3, 4), 0);
    rdchk("R8 upper flag clear", ra(3, 12), 0);
    wait_cyc(3);
    rdchk("R8 upper reload", ra(3, 4), 1);
    rdchk("R8 upper flag", ra(3, 12), 1);
    rdchk("R4 lower reload", ra(2, 4), 2);
  endtask

  task automatic t_ch0_cascade;
    wr(ra(0, 8), 0);
    wr(ra(0, 0), 4);
    wr(ra(0, 8), 5);
    wait_cyc(2);
    rdchk("R9 ch0 ignores cascade", ra(0, 4), 2);
  endtask

  task automatic t_unmapped;
    rdchk("R11 unmapped low", 9'h040, 0);
    rdchk("R11 past last channel", 9'h140, 0);
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count_flag();
    t_reload_write();
    t_disable();
    t_cascade();
    t_ch0_cascade();
    t_unmapped();
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

endmodule